// File: doc/BRIEF.md
# Stator Flux and Torque Estimator

This block estimates the stationary-frame stator flux vector and the electromagnetic torque of an induction machine, using per-unit fixed-point arithmetic. It is meant for a direct torque control loop. On each sample strobe it does four things. It takes three measured phase currents and maps them to two orthogonal axes. It rebuilds the two-axis stator voltage from the inverter switch pattern and the DC-link voltage; no voltage is measured. It integrates the back-EMF, which is the voltage minus the resistive drop. It then forms the torque as the cross product of flux and current.

The integrator guards against drift from offsets in its inputs in two ways. A small leakage term pulls the accumulator toward zero on every sample. A clamp holds the accumulator at a configured magnitude, so it never wraps. All quantities are signed Q1.14 words (16384 means 1.0 per unit). The accumulators carry 8 extra fraction bits. The per-sample integration step is a fixed power of two.

Top module: `flux_torque_est`

## Requirements
- R1: On a strobe, the alpha current equals ph_a. The beta current equals ((ph_b − ph_c)·9459) >>> 14, saturated to the 16-bit signed range.
- R2: Switch states use bit 0 for phase A, bit 1 for B and bit 2 for C, where 1 means upper switch on. The alpha voltage is (vdc·(2A−B−C)·5461) >>> 14. The beta voltage is (vdc·(B−C)·9459) >>> 14.
- R3: The back-EMF per axis is the axis voltage minus (r_stator·axis current) >>> 14.
- R4: Each axis accumulator is updated as acc − (acc >>> 10) + (emf·16) on every strobe. The accumulator has 8 fraction bits beyond Q14, and the reported flux is acc >>> 8.
- R5: Torque is (psi_alpha·i_beta − psi_beta·i_alpha) >>> 14. It uses the freshly updated flux and the same sample's currents, saturated to −32768..32767.
- R6: A strobe sampled on one rising edge produces exactly one est_valid pulse, which is high after the second rising edge that follows. Strobes on consecutive cycles give consecutive results in order.
- R7: After reset, est_valid, psi_alpha, psi_beta and torque are all 0.
- R8: The accumulator is clamped to ±(psi_limit·256) instead of wrapping. A sustained drive settles the flux at exactly +psi_limit or −psi_limit.
- R9: Without a strobe, the accumulators do not change, no leakage is applied, and the outputs hold their last values.
- R10: With zero voltage and zero current, each strobe moves a nonzero flux toward zero through the leakage term.
- R11: If psi_limit is lowered below the present flux, the next strobe clamps the flux to the new limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle sample strobe |
| ph_a | input | 16 | Phase A current, signed Q1.14 |
| ph_b | input | 16 | Phase B current, signed Q1.14 |
| ph_c | input | 16 | Phase C current, signed Q1.14 |
| sw_state | input | 3 | Inverter switch states, bit 0 = A, bit 1 = B, bit 2 = C |
| vdc | input | 16 | DC-link voltage, signed Q1.14 |
| r_stator | input | 16 | Stator resistance, signed Q1.14 |
| psi_limit | input | 15 | Flux clamp magnitude, unsigned Q14 |
| psi_alpha | output | 16 | Flux alpha component, signed Q1.14 |
| psi_beta | output | 16 | Flux beta component, signed Q1.14 |
| torque | output | 16 | Electromagnetic torque, signed Q1.14 |
| est_valid | output | 1 | One-cycle pulse when new outputs appear |

## Verification
The hardest states to reach from the ports are the two saturation conditions. The first is the accumulator resting against its clamp. The second is the torque word overflowing, which needs a flux near full scale together with a beta current whose conversion itself saturates. The stimulus reaches both by first lowering or raising the limit during idle cycles. It then applies a long run of strobes with one active voltage vector and zero resistance, so the flux climbs to the limit. Finally it applies extreme opposite phase B and C currents on the last sample. A bit-exact reference model runs in parallel and tracks the clamp, the leakage and the lowered limit sample by sample.

// File: rtl/flux_torque_est.sv
module flux_torque_est #(
  parameter int W        = 16,
  parameter int FR       = 8,
  parameter int DT_SHIFT = 4,
  parameter int LEAK_SH  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_stb,
  input  logic signed [W-1:0] ph_a,
  input  logic signed [W-1:0] ph_b,
  input  logic signed [W-1:0] ph_c,
  input  logic [2:0]          sw_state,
  input  logic signed [W-1:0] vdc,
  input  logic signed [W-1:0] r_stator,
  input  logic [W-2:0]        psi_limit,
  output logic signed [W-1:0] psi_alpha,
  output logic signed [W-1:0] psi_beta,
  output logic signed [W-1:0] torque,
  output logic                est_valid
);

  localparam int FRAC = W - 2;
  localparam int AW   = W + FR;
  localparam int SWD  = AW + 2;
  localparam int EW   = W + 2;
  localparam int PW   = 2 * W + 8;

  function automatic longint isqrt(input longint v);
    longint r;
    longint t;
    r = 0;
    for (int b = 30; b >= 0; b--) begin
      t = r | (longint'(1) << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  localparam longint K_ISQ3  = isqrt((longint'(1) << (2 * FRAC)) / 3);
  localparam longint K_THIRD = ((longint'(1) << FRAC) + 1) / 3;
  localparam logic signed [PW-1:0] C_ISQ3  = PW'(K_ISQ3);
  localparam logic signed [PW-1:0] C_THIRD = PW'(K_THIRD);
  localparam logic signed [PW-1:0] MAXV    = PW'((longint'(1) << (W - 1)) - 1);
  localparam logic signed [PW-1:0] MINV    = -MAXV - PW'(1);

  function automatic logic signed [W-1:0] sat_w(input logic signed [PW-1:0] v);
    if (v > MAXV)      return W'(MAXV);
    else if (v < MINV) return W'(MINV);
    else               return W'(v);
  endfunction

  function automatic logic signed [AW-1:0] acc_step(
    input logic signed [AW-1:0]  acc,
    input logic signed [EW-1:0]  emf,
    input logic signed [SWD-1:0] lim
  );
    logic signed [SWD-1:0] a;
    logic signed [SWD-1:0] n;
    a = SWD'(acc);
    n = a - (a >>> LEAK_SH) + (SWD'(emf) <<< (FR - DT_SHIFT));
    if (n > lim)       n = lim;
    else if (n < -lim) n = -lim;
    return AW'(n);
  endfunction

  // stage 1: frame conversion and voltage reconstruction
  logic signed [3:0]    sab, sbc;
  logic signed [PW-1:0] p_ibe, p_ual, p_ube;

  assign sab   = $signed({2'b00, sw_state[0], 1'b0}) - $signed({3'b000, sw_state[1]})
               - $signed({3'b000, sw_state[2]});
  assign sbc   = $signed({3'b000, sw_state[1]}) - $signed({3'b000, sw_state[2]});
  assign p_ibe = (PW'(ph_b) - PW'(ph_c)) * C_ISQ3;
  assign p_ual = PW'(vdc) * PW'(sab) * C_THIRD;
  assign p_ube = PW'(vdc) * PW'(sbc) * C_ISQ3;

  logic signed [W-1:0]  ial1, ibe1;
  logic signed [EW-1:0] ual1, ube1;
  logic                 v1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ial1 <= '0;
      ibe1 <= '0;
      ual1 <= '0;
      ube1 <= '0;
      v1   <= 1'b0;
    end else begin
      v1 <= sample_stb;
      if (sample_stb) begin
        ial1 <= ph_a;
        ibe1 <= sat_w(p_ibe >>> FRAC);
        ual1 <= EW'(p_ual >>> FRAC);
        ube1 <= EW'(p_ube >>> FRAC);
      end
    end
  end

  // stage 2: back-EMF and guarded integration
  logic signed [EW-1:0]  ea, eb;
  logic signed [SWD-1:0] lim_q;

  assign ea    = ual1 - EW'((PW'(r_stator) * PW'(ial1)) >>> FRAC);
  assign eb    = ube1 - EW'((PW'(r_stator) * PW'(ibe1)) >>> FRAC);
  assign lim_q = $signed({3'b000, psi_limit, {FR{1'b0}}});

  logic signed [AW-1:0] acc_a, acc_b;
  logic signed [W-1:0]  ial2, ibe2;
  logic                 v2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a <= '0;
      acc_b <= '0;
      ial2  <= '0;
      ibe2  <= '0;
      v2    <= 1'b0;
    end else begin
      v2 <= v1;
      if (v1) begin
        acc_a <= acc_step(acc_a, ea, lim_q);
        acc_b <= acc_step(acc_b, eb, lim_q);
        ial2  <= ial1;
        ibe2  <= ibe1;
      end
    end
  end

  // stage 3: torque and output registers
  logic signed [W-1:0]  pa_n, pb_n;
  logic signed [PW-1:0] tq_w;

  assign pa_n = W'(acc_a >>> FR);
  assign pb_n = W'(acc_b >>> FR);
  assign tq_w = (PW'(pa_n) * PW'(ibe2) - PW'(pb_n) * PW'(ial2)) >>> FRAC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psi_alpha <= '0;
      psi_beta  <= '0;
      torque    <= '0;
      est_valid <= 1'b0;
    end else begin
      est_valid <= v2;
      if (v2) begin
        psi_alpha <= pa_n;
        psi_beta  <= pb_n;
        torque    <= sat_w(tq_w);
      end
    end
  end

  p_valid_after_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> $past(sample_stb, 3));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !est_valid |-> ($stable(psi_alpha) && $stable(psi_beta) && $stable(torque)));

  p_psi_alpha_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> (psi_alpha <= $signed({1'b0, $past(psi_limit, 2)}) &&
                   psi_alpha >= -$signed({1'b0, $past(psi_limit, 2)})));

  p_psi_beta_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> (psi_beta <= $signed({1'b0, $past(psi_limit, 2)}) &&
                   psi_beta >= -$signed({1'b0, $past(psi_limit, 2)})));

endmodule

// File: tb/tb_flux_torque_est.sv
module tb_flux_torque_est;
  localparam int W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst_n;
  logic                sample_stb;
  logic signed [W-1:0] ph_a, ph_b, ph_c, vdc, r_stator;
  logic [2:0]          sw_state;
  logic [W-2:0]        psi_limit;
  logic signed [W-1:0] psi_alpha, psi_beta, torque;
  logic                est_valid;

  flux_torque_est dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
    .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c), .sw_state(sw_state),
    .vdc(vdc), .r_stator(r_stator), .psi_limit(psi_limit),
    .psi_alpha(psi_alpha), .psi_beta(psi_beta), .torque(torque),
    .est_valid(est_valid)
  );

  typedef struct { longint pa; longint pb; longint tq; int due; } exp_t;
  exp_t q[$];

  int     errors = 0;
  int     checks = 0;
  int     cyc = 0;
  bit     done = 0;
  longint m_aa = 0, m_ab = 0, m_lim = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint step(input longint acc, input longint e);
    longint n;
    n = acc - (acc >>> 10) + (e * 16);
    if (n > m_lim * 256) n = m_lim * 256;
    if (n < -m_lim * 256) n = -m_lim * 256;
    return n;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_lim(input int v);
    psi_limit = v[W-2:0];
    m_lim = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic sample(input int a, input int b, input int c, input logic [2:0] s,
                        input int u, input int r);
    longint sa, sb, sc, ial, ibe, ual, ube, ea, eb, pa, pb;
    exp_t x;
    sa = longint'(s[0]); sb = longint'(s[1]); sc = longint'(s[2]);
    ial = a;
    ibe = sat16(((longint'(b) - c) * 9459) >>> 14);
    ual = (longint'(u) * (2 * sa - sb - sc) * 5461) >>> 14;
    ube = (longint'(u) * (sb - sc) * 9459) >>> 14;
    ea  = ual - ((longint'(r) * ial) >>> 14);
    eb  = ube - ((longint'(r) * ibe) >>> 14);
    m_aa = step(m_aa, ea);
    m_ab = step(m_ab, eb);
    pa = m_aa >>> 8;
    pb = m_ab >>> 8;
    x.pa = pa; x.pb = pb;
    x.tq = sat16((pa * ibe - pb * ial) >>> 14);
    x.due = cyc + 3;
    q.push_back(x);
    ph_a = a[W-1:0]; ph_b = b[W-1:0]; ph_c = c[W-1:0];
    sw_state = s; vdc = u[W-1:0]; r_stator = r[W-1:0];
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && est_valid) begin
      if (q.size() == 0) begin
        chk("R6 unexpected valid", 1, 0);
      end else begin
        exp_t x;
        x = q.pop_front();
        chk("R6 latency", cyc, x.due);
        chk("R4 psi_alpha", psi_alpha, x.pa);
        chk("R4 psi_beta", psi_beta, x.pb);
        chk("R5 torque", torque, x.tq);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint held_a, held_b, held_t;
    rst_n = 1'b0; sample_stb = 1'b0;
    ph_a = '0; ph_b = '0; ph_c = '0; sw_state = '0;
    vdc = '0; r_stator = '0; psi_limit = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 psi_alpha", psi_alpha, 0);
    chk("R7 psi_beta", psi_beta, 0);
    chk("R7 torque", torque, 0);
    chk("R7 valid", est_valid, 0);

    set_lim(20000);
    // R1 R2 R3: every switch vector, spaced samples
    for (int s = 0; s < 8; s++) begin
      sample(3000 + s * 500, -2000 + s * 300, 1000 - s * 700, 3'(s), 12000, 800);
      repeat (3) @(negedge clk);
    end
    // R3: large resistive drop
    sample(-9000, 7000, 2000, 3'b100, 9000, 6000);
    repeat (3) @(negedge clk);
    // R6: back-to-back strobes
    for (int s = 0; s < 6; s++)
      sample(1500 * s - 4000, 2500 - 700 * s, 300 * s, 3'(7 - s), 15000, 1200);
    repeat (6) @(negedge clk);

    // R9: hold with no strobe
    held_a = psi_alpha; held_b = psi_beta; held_t = torque;
    repeat (30) @(negedge clk);
    chk("R9 psi_alpha hold", psi_alpha, held_a);
    chk("R9 psi_beta hold", psi_beta, held_b);
    chk("R9 torque hold", torque, held_t);

    // R8: clamp positive then negative
    set_lim(3000);
    for (int k = 0; k < 12; k++) sample(0, 0, 0, 3'b001, 16384, 0);
    repeat (4) @(negedge clk);
    chk("R8 positive clamp", psi_alpha, 3000);
    for (int k = 0; k < 14; k++) sample(0, 0, 0, 3'b110, 16384, 0);
    repeat (4) @(negedge clk);
    chk("R8 negative clamp", psi_alpha, -3000);

    // R11: lowered limit
    set_lim(1000);
    sample(0, 0, 0, 3'b000, 0, 0);
    repeat (4) @(negedge clk);
    chk("R11 new limit", psi_alpha, -1000);

    // R10: leakage toward zero
    for (int k = 0; k < 30; k++) sample(0, 0, 0, 3'b111, 0, 0);
    repeat (4) @(negedge clk);
    chk("R10 decayed", longint'(psi_alpha > -1000 && psi_alpha < 0), 1);

    // R5: torque saturation
    set_lim(32000);
    for (int k = 0; k < 30; k++) sample(0, 0, 0, 3'b001, 32767, 0);
    sample(0, 32767, -32768, 3'b001, 32767, 0);
    repeat (4) @(negedge clk);
    chk("R5 positive saturation", torque, 32767);
    sample(0, -32768, 32767, 3'b001, 32767, 0);
    repeat (4) @(negedge clk);
    chk("R5 negative saturation", torque, -32768);

    repeat (6) @(negedge clk);
    chk("R6 all results seen", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule